// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects single-event interrupt sources, ranks them by fixed priority and raises one request line to the processor. Each source has a pending bit, which a pulse on its source input sets, and an enable bit. The request line goes high only when an enabled pending source outranks the highest-ranked source that is currently marked in service. Source 0 ranks highest, and rank falls as the index rises.

Software acknowledges a request by writing 1 to a self-clearing bit in the vector register. In the next cycle the controller takes the winning source. It loads that source's vector number (index + 1) into the vector field, sets the source's in-service bit and clears its pending bit. If no source wins at that moment, the controller loads the error vector 0 and changes no other state. Software ends servicing by writing 1 to in-service bits. If software clears its own in-service bit early, a lower-ranked source can nest, provided it outranks every in-service bit that is still set.

The register port is a plain synchronous write with a combinational read. NUM_SRC must lie between 2 and 31, because vector numbers 1 to 31 map to sources 0 to 30.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the pending, enable, in-service and vector registers all read 0, and irq_o is low.
- R2: A high src_i[k] sets pending bit k at the clock edge. Writing 1 to a bit at address 0 clears that pending bit, and writing 0 has no effect. A source set wins over a software clear of the same bit in the same cycle.
- R3: The enable register at address 1 reads back what was written, with 1 meaning enabled. A pending source with enable 0 never raises irq_o.
- R4: irq_o is high exactly when an enabled pending source exists whose index is lower than the lowest index set in the in-service register. With nothing in service, any enabled pending source raises irq_o.
- R5: Writing 1 to bit 0 at address 3 sets the acknowledge bit. It reads 1 for exactly one cycle and then clears. An acknowledge write made while the bit is already set is ignored.
- R6: In the cycle the acknowledge bit is set, the winning source k is taken. Bits [15:11] at address 3 become k+1, in-service bit k is set and pending bit k is cleared. The vector field holds its value at all other times.
- R7: If no source wins in the acknowledge cycle, the vector field becomes 0 and the pending and in-service registers are unchanged.
- R8: In-service bits at address 2 are cleared by writing 1, and writing 0 has no effect. After an early clear, a lower-ranked pending source raises irq_o if it outranks the in-service bits that remain set.
- R9: Register bits at and above NUM_SRC read 0. At address 3, bits [10:1] and [31:16] read 0, and writes to any bit other than bit 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Source event inputs; a high bit sets the pending bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 pending, 1 enable, 2 in-service, 3 vector |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Request to the processor |

## Verification
The hardest state to reach is a nested one. Two sources are in service at once, the upper one is then cleared early, and a third pending source sits between them in rank. The stimulus builds this one step at a time. It takes a low-ranked source, injects a higher-ranked source and acknowledges it, and checks that the lower source stays blocked. It then clears the upper in-service bit, widens the enable set, and clears the remaining bit so that the blocked source wins. An acknowledge with nothing eligible is forced by clearing the last pending bit first, so the error vector and the untouched in-service register can be seen at the ports.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam int REG_W   = 32;
  localparam int VEC_W   = 5;
  localparam int VEC_LSB = 11;
  localparam int ACK_BIT = 0;
  localparam int VREG_W  = 16;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_ENA  = 2'd1,
    REG_INSV = 2'd2,
    REG_VECT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_first_set.sv
// Lowest set index of a vector (index 0 = highest rank).
module irq_first_set #(
  parameter int N  = 31,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 31,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  ena_i,
  input  logic [N-1:0]  insv_i,
  output logic          grant_o,
  output logic [IW-1:0] grant_idx_o
);
  logic          req_found, ceil_found;
  logic [IW-1:0] req_idx, ceil_idx;

  irq_first_set #(.N(N), .IW(IW)) u_req (
    .vec_i   (pend_i & ena_i),
    .found_o (req_found),
    .idx_o   (req_idx)
  );

  irq_first_set #(.N(N), .IW(IW)) u_ceil (
    .vec_i   (insv_i),
    .found_o (ceil_found),
    .idx_o   (ceil_idx)
  );

  // Pre-empt only above the highest in-service source.
  assign grant_o     = req_found && (!ceil_found || (req_idx < ceil_idx));
  assign grant_idx_o = req_idx;
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N  = 31,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic [N-1:0]  pend_clr_i,
  input  logic          ena_we_i,
  input  logic [N-1:0]  ena_wd_i,
  input  logic [N-1:0]  insv_clr_i,
  input  logic          take_i,
  input  logic [IW-1:0] take_idx_i,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  ena_o,
  output logic [N-1:0]  insv_o
);
  logic [N-1:0] pend_q, ena_q, insv_q;
  logic [N-1:0] take_oh;

  assign take_oh = take_i ? (N'(1) << take_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ena_q  <= '0;
      insv_q <= '0;
    end else begin
      pend_q <= (pend_q & ~pend_clr_i & ~take_oh) | src_i;
      insv_q <= (insv_q & ~insv_clr_i) | take_oh;
      if (ena_we_i) ena_q <= ena_wd_i;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;
  assign insv_o = insv_q;

  AST_SRC_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i))); // R2
  AST_INSV_ONE_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(insv_q & ~$past(insv_q))); // R6
  AST_INSV_SET_BY_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((insv_q & ~$past(insv_q)) != '0) |-> $past(take_i)); // R6
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam int IW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend, ena, insv;
  logic [NUM_SRC-1:0] pend_clr, insv_clr;
  logic               ena_we, ack_wr;
  logic               grant, take;
  logic [IW-1:0]      grant_idx;
  logic               ack_q;
  logic [VEC_W-1:0]   vec_q;
  logic [VREG_W-1:0]  vreg;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign ena_we   = wr_en_i && (addr_i == REG_ENA);
  assign pend_clr = (wr_en_i && addr_i == REG_PEND) ? wdata_i[NUM_SRC-1:0] : '0;
  assign insv_clr = (wr_en_i && addr_i == REG_INSV) ? wdata_i[NUM_SRC-1:0] : '0;
  assign ack_wr   = wr_en_i && (addr_i == REG_VECT) && wdata_i[ACK_BIT];

  irq_arbiter #(.N(NUM_SRC), .IW(IW)) u_arb (
    .pend_i      (pend),
    .ena_i       (ena),
    .insv_i      (insv),
    .grant_o     (grant),
    .grant_idx_o (grant_idx)
  );

  assign take = ack_q && grant;

  irq_src_regs #(.N(NUM_SRC), .IW(IW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .pend_clr_i (pend_clr),
    .ena_we_i   (ena_we),
    .ena_wd_i   (wdata_i[NUM_SRC-1:0]),
    .insv_clr_i (insv_clr),
    .take_i     (take),
    .take_idx_i (grant_idx),
    .pend_o     (pend),
    .ena_o      (ena),
    .insv_o     (insv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_wr && !ack_q;
      if (ack_q) vec_q <= grant ? (VEC_W'(grant_idx) + VEC_W'(1)) : '0;
    end
  end

  always_comb begin
    vreg                          = '0;
    vreg[VREG_W-1 -: VEC_W]       = vec_q;
    vreg[ACK_BIT]                 = ack_q;
  end

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      REG_PEND: rdata_o = REG_W'(pend);
      REG_ENA:  rdata_o = REG_W'(ena);
      REG_INSV: rdata_o = REG_W'(insv);
      default:  rdata_o = REG_W'(vreg);
    endcase
  end

  assign irq_o = grant;

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q); // R5
  AST_ERR_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && !irq_o) |=> (vec_q == '0)); // R7
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_q |=> $stable(vec_q)); // R6
  AST_IRQ_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend & ena) != '0)); // R4
  AST_IRQ_ENABLED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena == '0) |-> !irq_o); // R3
endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 31;

  typedef struct packed {
    logic        wr;
    logic [1:0]  a;
    logic [31:0] d;
    logic [31:0] s;
    logic [1:0]  ca;
    logic [31:0] e;
    logic        irq;
    logic [7:0]  rq;
  } step_t;

  localparam int NSTEP = 29;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 2'd1, 32'h30,       32'h0,  2'd1, 32'h30,       1'b0, 8'd3}, // R3 enable 4,5
    '{1'b0, 2'd0, 32'h0,        32'h40, 2'd0, 32'h40,       1'b0, 8'd3}, // R3 disabled src 6
    '{1'b0, 2'd0, 32'h0,        32'h20, 2'd0, 32'h60,       1'b1, 8'd4}, // R4 src 5
    '{1'b1, 2'd3, 32'h1,        32'h0,  2'd3, 32'h1,        1'b1, 8'd5}, // R5 ack bit visible
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd3, 32'h3000,     1'b0, 8'd6}, // R6 vec 6
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd2, 32'h20,       1'b0, 8'd6}, // R6 insv 5
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd0, 32'h40,       1'b0, 8'd6}, // R6 pend 5 cleared
    '{1'b0, 2'd0, 32'h0,        32'h20, 2'd0, 32'h60,       1'b0, 8'd4}, // R4 equal rank blocked
    '{1'b0, 2'd0, 32'h0,        32'h10, 2'd0, 32'h70,       1'b1, 8'd4}, // R4 higher rank nests
    '{1'b1, 2'd3, 32'h1,        32'h0,  2'd3, 32'h3001,     1'b1, 8'd5}, // R5
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd2, 32'h30,       1'b0, 8'd6}, // R6 two in service
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd3, 32'h2800,     1'b0, 8'd6}, // R6 vec 5
    '{1'b1, 2'd2, 32'h10,       32'h0,  2'd2, 32'h20,       1'b0, 8'd8}, // R8 clear insv 4
    '{1'b1, 2'd2, 32'h0,        32'h0,  2'd2, 32'h20,       1'b0, 8'd8}, // R8 zero write
    '{1'b1, 2'd1, 32'h70,       32'h0,  2'd1, 32'h70,       1'b0, 8'd4}, // R4 src 6 below ceiling
    '{1'b1, 2'd2, 32'h20,       32'h0,  2'd2, 32'h0,        1'b1, 8'd8}, // R8 early clear
    '{1'b1, 2'd3, 32'h1,        32'h0,  2'd3, 32'h2801,     1'b1, 8'd5}, // R5
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd3, 32'h3000,     1'b0, 8'd6}, // R6
    '{1'b1, 2'd0, 32'h40,       32'h0,  2'd0, 32'h0,        1'b0, 8'd2}, // R2 W1C pending
    '{1'b1, 2'd3, 32'h1,        32'h0,  2'd3, 32'h3001,     1'b0, 8'd5}, // R5 ack with no winner
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd3, 32'h0,        1'b0, 8'd7}, // R7 error vector
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd2, 32'h20,       1'b0, 8'd7}, // R7 insv unchanged
    '{1'b1, 2'd1, 32'hFFFFFFFF, 32'h0,  2'd1, 32'h7FFFFFFF, 1'b0, 8'd9}, // R9 top bit zero
    '{1'b1, 2'd2, 32'hFFFFFFFF, 32'h0,  2'd2, 32'h0,        1'b0, 8'd9}, // R9
    '{1'b0, 2'd0, 32'h0,        32'h1,  2'd0, 32'h1,        1'b1, 8'd4}, // R4 src 0
    '{1'b1, 2'd0, 32'h1,        32'h1,  2'd0, 32'h1,        1'b1, 8'd2}, // R2 set beats clear
    '{1'b1, 2'd3, 32'hFFFF,     32'h0,  2'd3, 32'h1,        1'b1, 8'd9}, // R9 only ack writable
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd3, 32'h800,      1'b0, 8'd6}, // R6 vec 1
    '{1'b0, 2'd0, 32'h0,        32'h0,  2'd0, 32'h0,        1'b0, 8'd6}  // R6
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] src_i = '0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  nest_irq_ctrl #(.NUM_SRC(NS)) u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic check_all_zero();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      check(1, $sformatf("reg %0d after reset", a), v, 32'h0); // R1
    end
    check(1, "irq after reset", {31'h0, irq_o}, 32'h0); // R1
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk_i);
    #1;
    check_all_zero();
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < NSTEP; k++) begin
      @(negedge clk_i);
      wr_en_i = TBL[k].wr;
      addr_i  = TBL[k].a;
      wdata_i = TBL[k].d;
      src_i   = TBL[k].s[NS-1:0];
      @(posedge clk_i);
      #1;
      wr_en_i = 1'b0;
      src_i   = '0;
      wdata_i = '0;
      peek(TBL[k].ca, v);
      check(int'(TBL[k].rq), $sformatf("step %0d reg %0d", k, TBL[k].ca), v, TBL[k].e);
      check(int'(TBL[k].rq), $sformatf("step %0d irq", k), {31'h0, irq_o}, {31'h0, TBL[k].irq});
    end
    // R1: reset in mid-operation returns everything to zero
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check_all_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule